// File: doc/BRIEF.md
# GPIO Pad Configuration Register File

This block holds the configuration of one community of GPIO pads behind a simple 32-bit read/write bus. Every pad has two configuration words. The first holds the function select, the receive and transmit buffer disables, the driven output value and a read-only view of the pad input. The second holds the pull termination as a strength code plus a direction bit. The stored fields drive the pad controls directly: output enable, output value, function select, termination strength and pull direction.

Two further register sets decide whether a pad's words can be written. The ownership registers hold a 4-bit owner field per pad. Any nonzero value hands the pad to another agent. The lock registers come in pairs, one pair for each group of pads. One register of the pair freezes the whole configuration. The other freezes everything except the output value. A fixed register reports where the pad configuration array starts, so software can find it without a hard-coded address.

Bus reads return data one cycle after the request. Writes take effect at the clock edge that samples the request.

Top module: `pad_cfg_regfile`

## Requirements
- R1: After reset every pad's first word reads 0x100: function 0, receive enabled, transmit buffer disabled, output value 0. Every second word reads 0. `oe_o`, `out_o`, `mode_o`, `term_o` and `pull_up_o` are all zero.
- R2: A read request to byte address 0x00C returns the array start `PAD_BASE` (default 0x400) in `rdata_o` on the cycle after the request.
- R3: Pad p's first word is at `PAD_BASE + 8*p` and its second word at `PAD_BASE + 8*p + 4`. In the first word, bits 13:10 are the function (0 = GPIO), bit 9 disables receive, bit 8 disables transmit, bit 1 is the input state and bit 0 is the output value. All other bits read 0.
- R4: `oe_o[p]` is high exactly when pad p's transmit-disable bit is clear. `out_o[p]` follows the output value bit. `mode_o[4p+3:4p]` carries the function field.
- R5: In the second word, bits 12:10 hold the termination code and bit 13 selects pull-up when 1 and pull-down when 0. The code values are 0 none, 1 1k, 2 2k, 3 5k and 4 20k, stored as written. All other bits read 0. The fields drive `term_o[3p+2:3p]` and `pull_up_o[p]`.
- R6: The ownership register for pad p is at 0x020 + 4*(p/8), with pad p's field in bits 4*(p%8)+3 : 4*(p%8). Fields of pads that do not exist read 0. A nonzero field makes writes to both of pad p's words have no effect.
- R7: The configuration lock for pad p is bit p%8 of 0x080 + 8*(p/8). The transmit lock for pad p is the same bit at that address + 4. Bits of pads that do not exist read 0. A set configuration lock makes writes to both of pad p's words have no effect.
- R8: When only the transmit lock of an owned pad is set, a write to the first word updates only bit 0, and a write to the second word has no effect.
- R9: Bit 1 of the first word reads `pad_i[p]` after a two-stage synchronizer, and reads 0 while receive is disabled. Writes to bit 1 are ignored.
- R10: Reads of unmapped or misaligned addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| pad_i | input | NUM_PADS | Raw pad inputs |
| oe_o | output | NUM_PADS | Output driver enables |
| out_o | output | NUM_PADS | Driven output values |
| mode_o | output | 4*NUM_PADS | Function select per pad |
| term_o | output | 3*NUM_PADS | Termination code per pad |
| pull_up_o | output | NUM_PADS | Pull direction per pad, 1 = up |

## Verification
The bench builds the block with `NUM_PADS` = 12, eight pads per lock group and two synchronizer stages. With 12 pads, the second ownership register and the second lock pair are each only partly populated, so masking of nonexistent pad fields can be checked at read-back. The address just past the last pad word falls inside the region's natural power-of-two span but outside the array, which makes the end-of-array decode observable. Ownership, configuration lock and transmit lock are each applied to a different pad, and the effect of each is checked through both read-back and the pad control outputs.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;
  localparam int MODE_W   = 4;
  localparam int TERM_W   = 3;
  localparam int OWN_W    = 4;
  localparam int OWN_PER  = 8;
  localparam int W_MODE   = 10;
  localparam int W_RXDIS  = 9;
  localparam int W_TXDIS  = 8;
  localparam int W_RXST   = 1;
  localparam int W_TXST   = 0;
  localparam int W_TERM   = 10;
  localparam int W_UP     = 13;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              rx_dis;
    logic              tx_dis;
    logic              tx_st;
  } cfg0_t;

  typedef struct packed {
    logic              up;
    logic [TERM_W-1:0] term;
  } cfg1_t;

  localparam cfg0_t CFG0_RST = '{mode: '0, rx_dis: 1'b0, tx_dis: 1'b1, tx_st: 1'b0};
  localparam cfg1_t CFG1_RST = '{up: 1'b0, term: '0};

  function automatic cfg0_t unpack0(logic [31:0] w);
    cfg0_t c;
    c.mode   = w[W_MODE +: MODE_W];
    c.rx_dis = w[W_RXDIS];
    c.tx_dis = w[W_TXDIS];
    c.tx_st  = w[W_TXST];
    return c;
  endfunction

  function automatic cfg1_t unpack1(logic [31:0] w);
    cfg1_t c;
    c.up   = w[W_UP];
    c.term = w[W_TERM +: TERM_W];
    return c;
  endfunction

  function automatic logic [31:0] pack0(cfg0_t c, logic rx);
    logic [31:0] w;
    w = '0;
    w[W_MODE +: MODE_W] = c.mode;
    w[W_RXDIS] = c.rx_dis;
    w[W_TXDIS] = c.tx_dis;
    w[W_RXST]  = rx;
    w[W_TXST]  = c.tx_st;
    return w;
  endfunction

  function automatic logic [31:0] pack1(cfg1_t c);
    logic [31:0] w;
    w = '0;
    w[W_UP] = c.up;
    w[W_TERM +: TERM_W] = c.term;
    return w;
  endfunction
endpackage

// File: rtl/pad_in_sync.sv
module pad_in_sync #(
  parameter int NUM_PADS = 16,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] pad_i,
  output logic [NUM_PADS-1:0] sync_o
);
  logic [NUM_PADS-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= '0;
        else         chain_q[0] <= pad_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pad_cfg_perm.sv
module pad_cfg_perm #(
  parameter int          NUM_PADS  = 16,
  parameter int          GRP_PADS  = 8,
  parameter int          ADDR_W    = 12,
  parameter int unsigned OWN_BASE  = 32'h020,
  parameter int unsigned LOCK_BASE = 32'h080
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [NUM_PADS-1:0] owned_o,
  output logic [NUM_PADS-1:0] cfg_lock_o,
  output logic [NUM_PADS-1:0] tx_lock_o,
  output logic                hit_o,
  output logic [31:0]         rdata_o
);
  import pad_cfg_pkg::*;

  localparam int NUM_OWN = (NUM_PADS + OWN_PER - 1) / OWN_PER;
  localparam int NUM_GRP = (NUM_PADS + GRP_PADS - 1) / GRP_PADS;
  localparam logic [ADDR_W-1:0] OWN_A   = ADDR_W'(OWN_BASE);
  localparam logic [ADDR_W-1:0] LOCK_A  = ADDR_W'(LOCK_BASE);
  localparam logic [ADDR_W-1:0] OWN_SP  = ADDR_W'(4 * NUM_OWN);
  localparam logic [ADDR_W-1:0] LOCK_SP = ADDR_W'(8 * NUM_GRP);

  logic [ADDR_W-1:0] own_off, lock_off, own_idx, grp_idx;
  logic own_hit, lock_hit, lock_tx;

  assign own_off  = addr_i - OWN_A;
  assign lock_off = addr_i - LOCK_A;
  assign own_hit  = (addr_i[1:0] == 2'b00) && (addr_i >= OWN_A) && (own_off < OWN_SP);
  assign lock_hit = (addr_i[1:0] == 2'b00) && (addr_i >= LOCK_A) && (lock_off < LOCK_SP);
  assign own_idx  = own_off >> 2;
  assign grp_idx  = lock_off >> 3;
  assign lock_tx  = lock_off[2];
  assign hit_o    = own_hit | lock_hit;

  logic [OWN_W-1:0] own_q [NUM_PADS];
  logic [NUM_PADS-1:0] cl_q, tl_q;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int K = p / OWN_PER;
    localparam int F = p % OWN_PER;
    localparam int G = p / GRP_PADS;
    localparam int B = p % GRP_PADS;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        own_q[p] <= '0;
        cl_q[p]  <= 1'b0;
        tl_q[p]  <= 1'b0;
      end else if (wr_i) begin
        if (own_hit && own_idx == ADDR_W'(K)) own_q[p] <= wdata_i[OWN_W*F +: OWN_W];
        if (lock_hit && grp_idx == ADDR_W'(G)) begin
          if (lock_tx) tl_q[p] <= wdata_i[B];
          else         cl_q[p] <= wdata_i[B];
        end
      end
    end

    assign owned_o[p] = (own_q[p] == '0);
  end

  assign cfg_lock_o = cl_q;
  assign tx_lock_o  = tl_q;

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (own_hit && own_idx == ADDR_W'(p / OWN_PER))
        rdata_o[OWN_W*(p % OWN_PER) +: OWN_W] = own_q[p];
      if (lock_hit && grp_idx == ADDR_W'(p / GRP_PADS))
        rdata_o[p % GRP_PADS] = lock_tx ? tl_q[p] : cl_q[p];
    end
  end
endmodule

// File: rtl/pad_cfg_slice.sv
module pad_cfg_slice (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr0_i,
  input  logic                 wr1_i,
  input  pad_cfg_pkg::cfg0_t   wcfg0_i,
  input  pad_cfg_pkg::cfg1_t   wcfg1_i,
  input  logic                 owned_i,
  input  logic                 cfg_lock_i,
  input  logic                 tx_lock_i,
  output pad_cfg_pkg::cfg0_t   cfg0_o,
  output pad_cfg_pkg::cfg1_t   cfg1_o
);
  import pad_cfg_pkg::*;

  cfg0_t cfg0_q;
  cfg1_t cfg1_q;
  logic  may_tx, may_all;

  assign may_tx  = owned_i & ~cfg_lock_i;
  assign may_all = may_tx & ~tx_lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg0_q <= CFG0_RST;
      cfg1_q <= CFG1_RST;
    end else begin
      if (wr0_i && may_all)     cfg0_q       <= wcfg0_i;
      else if (wr0_i && may_tx) cfg0_q.tx_st <= wcfg0_i.tx_st;
      if (wr1_i && may_all)     cfg1_q       <= wcfg1_i;
    end
  end

  assign cfg0_o = cfg0_q;
  assign cfg1_o = cfg1_q;

  // R6 and R7: a blocked pad keeps both words
  assert_blocked_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr0_i || wr1_i) && (!owned_i || cfg_lock_i)) |=> ($stable(cfg0_q) && $stable(cfg1_q)));

  assert_txlock_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr0_i || wr1_i) && owned_i && !cfg_lock_i && tx_lock_i)
      |=> ($stable(cfg0_q.mode) && $stable(cfg0_q.rx_dis) && $stable(cfg0_q.tx_dis)
           && $stable(cfg1_q)));
endmodule

// File: rtl/pad_cfg_regfile.sv
module pad_cfg_regfile #(
  parameter int          NUM_PADS    = 16,
  parameter int          GRP_PADS    = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 12,
  parameter int unsigned BASE_REG    = 32'h00C,
  parameter int unsigned OWN_BASE    = 32'h020,
  parameter int unsigned LOCK_BASE   = 32'h080,
  parameter int unsigned PAD_BASE    = 32'h400
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PADS-1:0]   pad_i,
  output logic [NUM_PADS-1:0]   oe_o,
  output logic [NUM_PADS-1:0]   out_o,
  output logic [4*NUM_PADS-1:0] mode_o,
  output logic [3*NUM_PADS-1:0] term_o,
  output logic [NUM_PADS-1:0]   pull_up_o
);
  import pad_cfg_pkg::*;

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_REG);
  localparam logic [ADDR_W-1:0] PAD_A  = ADDR_W'(PAD_BASE);
  localparam logic [ADDR_W-1:0] PAD_SP = ADDR_W'(8 * NUM_PADS);

  logic                rd, wr;
  logic [ADDR_W-1:0]   pad_off, pad_idx;
  logic                pad_hit, base_hit, perm_hit, word1;
  logic [31:0]         perm_rd, pad_rd;
  logic [NUM_PADS-1:0] owned, cfg_lock, tx_lock, rx_sync, rx_vis;
  cfg0_t               cfg0 [NUM_PADS];
  cfg1_t               cfg1 [NUM_PADS];
  cfg0_t               wcfg0;
  cfg1_t               wcfg1;

  assign rd       = req_i & ~we_i;
  assign wr       = req_i & we_i;
  assign pad_off  = addr_i - PAD_A;
  assign pad_hit  = (addr_i[1:0] == 2'b00) && (addr_i >= PAD_A) && (pad_off < PAD_SP);
  assign pad_idx  = pad_off >> 3;
  assign word1    = pad_off[2];
  assign base_hit = (addr_i == BASE_A);
  assign wcfg0    = unpack0(wdata_i);
  assign wcfg1    = unpack1(wdata_i);

  pad_cfg_perm #(
    .NUM_PADS(NUM_PADS), .GRP_PADS(GRP_PADS), .ADDR_W(ADDR_W),
    .OWN_BASE(OWN_BASE), .LOCK_BASE(LOCK_BASE)
  ) i_perm (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i, .wdata_i,
    .owned_o(owned), .cfg_lock_o(cfg_lock), .tx_lock_o(tx_lock),
    .hit_o(perm_hit), .rdata_o(perm_rd)
  );

  pad_in_sync #(.NUM_PADS(NUM_PADS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .pad_i, .sync_o(rx_sync)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic sel;
    assign sel = wr && pad_hit && (pad_idx == ADDR_W'(p));

    pad_cfg_slice i_slice (
      .clk_i, .rst_ni,
      .wr0_i(sel & ~word1), .wr1_i(sel & word1),
      .wcfg0_i(wcfg0), .wcfg1_i(wcfg1),
      .owned_i(owned[p]), .cfg_lock_i(cfg_lock[p]), .tx_lock_i(tx_lock[p]),
      .cfg0_o(cfg0[p]), .cfg1_o(cfg1[p])
    );

    assign rx_vis[p]               = rx_sync[p] & ~cfg0[p].rx_dis;
    assign oe_o[p]                 = ~cfg0[p].tx_dis;
    assign out_o[p]                = cfg0[p].tx_st;
    assign mode_o[4*p +: 4]        = cfg0[p].mode;
    assign term_o[3*p +: 3]        = cfg1[p].term;
    assign pull_up_o[p]            = cfg1[p].up;
  end

  always_comb begin
    pad_rd = '0;
    for (int p = 0; p < NUM_PADS; p++)
      if (pad_idx == ADDR_W'(p))
        pad_rd = word1 ? pack1(cfg1[p]) : pack0(cfg0[p], rx_vis[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (rd) begin
      if (base_hit)      rdata_o <= PAD_BASE;
      else if (pad_hit)  rdata_o <= pad_rd;
      else if (perm_hit) rdata_o <= perm_rd;
      else               rdata_o <= '0;
    end
  end

  assert_base_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == BASE_A) |=> (rdata_o == PAD_BASE));

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !base_hit && !pad_hit && !perm_hit) |=> (rdata_o == 32'h0));
endmodule

// File: tb/test_pad_cfg_regfile.sv
`timescale 1ns/1ps
module test_pad_cfg_regfile;
  localparam int N  = 12;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pad = '0;
  logic [N-1:0]  oe, outv, pull_up;
  logic [4*N-1:0] mode;
  logic [3*N-1:0] term;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pad_cfg_regfile #(.NUM_PADS(N), .GRP_PADS(8), .SYNC_STAGES(2), .ADDR_W(AW)) i_pad_cfg_regfile (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .oe_o(oe), .out_o(outv),
    .mode_o(mode), .term_o(term), .pull_up_o(pull_up)
  );

  // {we, req tag, addr, wdata, expected read data}
  localparam int NV = 18;
  localparam logic [84:0] VEC [NV] = '{
    {1'b1, 4'd3,  16'h0400, 32'hFFFF2C03, 32'h0},          // R3 pad0 word0, junk bits dropped
    {1'b0, 4'd3,  16'h0400, 32'h0,        32'h00002C01},   // R3
    {1'b1, 4'd5,  16'h0404, 32'h00003000, 32'h0},          // R5 pull-up 20k
    {1'b0, 4'd5,  16'h0404, 32'h0,        32'h00003000},   // R5
    {1'b1, 4'd5,  16'h045C, 32'hFFFFFFFF, 32'h0},          // R5 last pad word1
    {1'b0, 4'd5,  16'h045C, 32'h0,        32'h00003C00},   // R5
    {1'b0, 4'd10, 16'h0460, 32'h0,        32'h0},          // R10 past end of array
    {1'b1, 4'd10, 16'h0460, 32'hFFFFFFFF, 32'h0},          // R10
    {1'b0, 4'd10, 16'h0460, 32'h0,        32'h0},          // R10
    {1'b0, 4'd2,  16'h000C, 32'h0,        32'h00000400},   // R2
    {1'b0, 4'd10, 16'h0402, 32'h0,        32'h0},          // R10 misaligned
    {1'b1, 4'd6,  16'h0024, 32'hFFFFFFFF, 32'h0},          // R6 partial owner reg
    {1'b0, 4'd6,  16'h0024, 32'h0,        32'h0000FFFF},   // R6
    {1'b1, 4'd6,  16'h0024, 32'h0,        32'h0},          // R6
    {1'b1, 4'd7,  16'h0088, 32'h000000FF, 32'h0},          // R7 partial lock group
    {1'b0, 4'd7,  16'h0088, 32'h0,        32'h0000000F},   // R7
    {1'b1, 4'd7,  16'h0088, 32'h0,        32'h0},          // R7
    {1'b0, 4'd7,  16'h0088, 32'h0,        32'h0}           // R7
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(12'h400, d); check("R1 word0", d, 32'h100);
    bus_rd(12'h404, d); check("R1 word1", d, 32'h0);
    check("R1 oe", 32'(oe), 32'h0);
    check("R1 mode", 32'(mode[31:0]), 32'h0);
    check("R1 term", 32'(term[31:0]), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][84]) bus_wr(VEC[i][AW-1+64:64], VEC[i][63:32]);
      else begin
        bus_rd(VEC[i][AW-1+64:64], d);
        check($sformatf("R%0d vec%0d", VEC[i][83:80], i), d, VEC[i][31:0]);
      end
    end

    // R4 outputs from pad0
    check("R4 oe", 32'(oe[1:0]), 32'h1);
    check("R4 out", 32'(outv[0]), 32'h1);
    check("R4 mode", 32'(mode[3:0]), 32'hB);
    // R5 termination outputs
    check("R5 term0", 32'(term[2:0]), 32'h4);
    check("R5 up0", 32'(pull_up[0]), 32'h1);
    check("R5 term11", 32'(term[35:33]), 32'h7);

    // R6 pad2 owned elsewhere
    bus_wr(12'h020, 32'h00000100);
    bus_wr(12'h410, 32'h00000001);
    bus_rd(12'h410, d); check("R6 blocked", d, 32'h100);
    check("R6 oe", 32'(oe[2]), 32'h0);
    bus_wr(12'h020, 32'h0);
    bus_wr(12'h410, 32'h00000001);
    bus_rd(12'h410, d); check("R6 released", d, 32'h1);

    // R7 pad3 configuration lock
    bus_wr(12'h080, 32'h00000008);
    bus_wr(12'h418, 32'h00002C01);
    bus_wr(12'h41C, 32'h00001400);
    bus_rd(12'h418, d); check("R7 word0", d, 32'h100);
    bus_rd(12'h41C, d); check("R7 word1", d, 32'h0);
    bus_wr(12'h080, 32'h0);

    // R8 pad4 transmit lock only
    bus_wr(12'h084, 32'h00000010);
    bus_wr(12'h420, 32'h00002C01);
    bus_wr(12'h424, 32'h00001400);
    bus_rd(12'h420, d); check("R8 word0", d, 32'h101);
    bus_rd(12'h424, d); check("R8 word1", d, 32'h0);
    check("R8 out", 32'(outv[4]), 32'h1);
    check("R8 oe", 32'(oe[4]), 32'h0);
    bus_wr(12'h084, 32'h0);

    // R9 input state on pad5
    @(negedge clk); pad[5] = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(12'h428, d); check("R9 rx", d, 32'h102);
    bus_wr(12'h428, 32'h00000300);
    bus_rd(12'h428, d); check("R9 rx masked", d, 32'h300);
    @(negedge clk); pad[5] = 1'b0;
    repeat (3) @(negedge clk);
    bus_wr(12'h428, 32'h00000002);
    bus_rd(12'h428, d); check("R9 rx not writable", d, 32'h0);

    finish_run();
  end
endmodule